// File: doc/BRIEF.md
# Dual-Port Semaphore Token Unit

This block keeps a small set of one-bit tokens that two independent ports, left and right, use to claim shared resources. Each port presents a select strobe, a write enable, a token address and a single write bit. A port asks for a token by writing 0 and gives it back by writing 1. When a token is free, the asking port takes it straight away. When the other port holds it, the request is kept as pending and is granted in the same cycle that the holder releases the token.

Each port also reads its own view of a token. A token that this port holds reads 0. A token that is free, or that the opposite port holds, reads 1. The read result is copied to every bit of a 9-bit output register. The register is loaded on the clock edge of a read strobe and keeps its value until the next read on that port. Writes from either port therefore cannot change a value that has already been captured.

The design is fully synchronous, with one clock and an active-high synchronous reset.

Top module: `sem_token_unit`

## Requirements
- R1: There are eight tokens, chosen by the 3-bit port address. An access to one token never changes the state of any other token.
- R2: A write is a cycle with sel=1 and we=1. Write bit value 0 requests the addressed token and value 1 releases it. If the writing port does not hold the token, writing 1 instead withdraws that port's pending request.
- R3: A read is a cycle with sel=1 and we=0. The read output takes the port's view of the token on the next clock edge. The view is 0 when this port holds the token, and 1 when the token is free or held by the opposite port. The output keeps its value in every cycle without a read strobe.
- R4: After reset every token is free, no request is pending, and both read outputs are all ones.
- R5: A 0 written by a port while the opposite port holds the token leaves both ports' views unchanged.
- R6: If a port has a pending request and the holder writes 1, ownership passes to the waiting port at that clock edge.
- R7: A pending request that has been withdrawn by writing 1 is not granted when the holder later releases the token.
- R8: If both ports write 0 to the same free token in the same cycle, the left port wins and the right port's request becomes pending.
- R9: A port that writes 1 to a token it neither holds nor has requested causes no change.
- R10: All 9 read bits carry the same value. A read samples the token state as it was before any write in the same cycle, so a handoff caused by the opposite port in that cycle does not appear in the captured value.
- R11: No token is ever held by both ports at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sel | input | 1 | Left port access strobe |
| l_we | input | 1 | Left port write enable (1 write, 0 read) |
| l_addr | input | 3 | Left port token address |
| l_wdat | input | 1 | Left port write bit (0 request, 1 release) |
| l_rdata | output | 9 | Left port registered token view |
| r_sel | input | 1 | Right port access strobe |
| r_we | input | 1 | Right port write enable (1 write, 0 read) |
| r_addr | input | 3 | Right port token address |
| r_wdat | input | 1 | Right port write bit (0 request, 1 release) |
| r_rdata | output | 9 | Right port registered token view |

## Verification
The hardest case to reach from the ports is a read that falls in the same cycle as the opposite port's release, while a request from the reading port is pending. Only that combination can show whether the captured value is the state before or after the handoff. To reach it, the bench first makes the left port the holder and records a pending right request. It then strobes a right-port read in the same cycle as the left release. It checks that the right port captured 1, that this value holds through idle cycles, and that a fresh read returns 0. The bench runs the full request, block, release, withdraw and tie sequence on every one of the eight tokens, and checks that a neighbouring token stays free each time.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef struct packed {
    logic own_l;
    logic own_r;
    logic pend_l;
    logic pend_r;
  } tok_state_t;

  localparam int unsigned TOK_CNT_DEF = 8;
  localparam int unsigned RD_W_DEF    = 9;
endpackage

// File: rtl/sem_token_cell.sv
module sem_token_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic l_wr,
  input  logic l_bit,
  input  logic r_wr,
  input  logic r_bit,
  output logic own_l,
  output logic own_r,
  output logic pend_l,
  output logic pend_r
);
  tok_state_t st_q, st_d;
  logic want_l, want_r;

  always_comb begin
    want_l = l_wr ? ~l_bit : (st_q.own_l | st_q.pend_l);
    want_r = r_wr ? ~r_bit : (st_q.own_r | st_q.pend_r);
    st_d   = '0;
    if (st_q.own_l) begin
      st_d.own_l = want_l;
      st_d.own_r = ~want_l & want_r;
    end else if (st_q.own_r) begin
      st_d.own_r = want_r;
      st_d.own_l = ~want_r & want_l;
    end else begin
      st_d.own_l = want_l;
      st_d.own_r = ~want_l & want_r;
    end
    st_d.pend_l = want_l & ~st_d.own_l;
    st_d.pend_r = want_r & ~st_d.own_r;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end

  assign own_l  = st_q.own_l;
  assign own_r  = st_q.own_r;
  assign pend_l = st_q.pend_l;
  assign pend_r = st_q.pend_r;
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
  parameter int unsigned TOK_CNT = 8,
  parameter int unsigned RD_W    = 9,
  localparam int unsigned AW     = $clog2(TOK_CNT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [AW-1:0]      addr,
  input  logic [TOK_CNT-1:0] view,
  output logic [RD_W-1:0]    rdata
);
  always_ff @(posedge clk) begin
    if (rst)        rdata <= '1;
    else if (rd_en) rdata <= {RD_W{view[addr]}};
  end
endmodule

// File: rtl/sem_token_unit.sv
module sem_token_unit
  import sem_pkg::*;
#(
  parameter int unsigned TOK_CNT = TOK_CNT_DEF,
  parameter int unsigned RD_W    = RD_W_DEF,
  localparam int unsigned AW     = $clog2(TOK_CNT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            l_sel,
  input  logic            l_we,
  input  logic [AW-1:0]   l_addr,
  input  logic            l_wdat,
  output logic [RD_W-1:0] l_rdata,
  input  logic            r_sel,
  input  logic            r_we,
  input  logic [AW-1:0]   r_addr,
  input  logic            r_wdat,
  output logic [RD_W-1:0] r_rdata
);
  logic [TOK_CNT-1:0] own_l_vec, own_r_vec, pend_l_vec, pend_r_vec;

  for (genvar i = 0; i < TOK_CNT; i++) begin : g_tok
    logic l_hit, r_hit;
    assign l_hit = l_sel & l_we & (l_addr == AW'(i));
    assign r_hit = r_sel & r_we & (r_addr == AW'(i));
    sem_token_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .l_wr  (l_hit),
      .l_bit (l_wdat),
      .r_wr  (r_hit),
      .r_bit (r_wdat),
      .own_l (own_l_vec[i]),
      .own_r (own_r_vec[i]),
      .pend_l(pend_l_vec[i]),
      .pend_r(pend_r_vec[i])
    );
  end

  sem_read_port #(.TOK_CNT(TOK_CNT), .RD_W(RD_W)) u_rd_l (
    .clk  (clk),
    .rst  (rst),
    .rd_en(l_sel & ~l_we),
    .addr (l_addr),
    .view (~own_l_vec),
    .rdata(l_rdata)
  );

  sem_read_port #(.TOK_CNT(TOK_CNT), .RD_W(RD_W)) u_rd_r (
    .clk  (clk),
    .rst  (rst),
    .rd_en(r_sel & ~r_we),
    .addr (r_addr),
    .view (~own_r_vec),
    .rdata(r_rdata)
  );
endmodule

// File: rtl/sem_token_unit_chk.sv
module sem_token_unit_chk #(
  parameter int unsigned TOK_CNT = 8,
  parameter int unsigned RD_W    = 9,
  localparam int unsigned AW     = $clog2(TOK_CNT)
) (
  input logic               clk,
  input logic               rst,
  input logic               l_sel,
  input logic               l_we,
  input logic [AW-1:0]      l_addr,
  input logic               l_wdat,
  input logic [RD_W-1:0]    l_rdata,
  input logic               r_sel,
  input logic               r_we,
  input logic [AW-1:0]      r_addr,
  input logic               r_wdat,
  input logic [RD_W-1:0]    r_rdata,
  input logic [TOK_CNT-1:0] own_l_vec,
  input logic [TOK_CNT-1:0] own_r_vec,
  input logic [TOK_CNT-1:0] pend_r_vec
);
  logic l_w, r_w, same;
  assign l_w  = l_sel & l_we;
  assign r_w  = r_sel & r_we;
  assign same = (l_addr == r_addr);

  AST_EXCL_OWN: assert property (@(posedge clk) disable iff (rst)
    (own_l_vec & own_r_vec) == '0); // R11

  AST_RD_REPLICATE: assert property (@(posedge clk) disable iff (rst)
    (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1)); // R10

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(l_sel && !l_we) |=> $stable(l_rdata)); // R3

  AST_TIE_LEFT: assert property (@(posedge clk) disable iff (rst)
    (l_w && r_w && same && !l_wdat && !r_wdat &&
     !own_l_vec[l_addr] && !own_r_vec[l_addr])
    |=> own_l_vec[$past(l_addr)] && pend_r_vec[$past(l_addr)]); // R8

  AST_NONHOLDER_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (r_w && !r_wdat && own_l_vec[r_addr] && !(l_w && same))
    |=> own_l_vec[$past(r_addr)] && !own_r_vec[$past(r_addr)]); // R5

  AST_HANDOFF: assert property (@(posedge clk) disable iff (rst)
    (l_w && l_wdat && own_l_vec[l_addr] && pend_r_vec[l_addr] && !(r_w && same))
    |=> own_r_vec[$past(l_addr)]); // R6
endmodule

bind sem_token_unit sem_token_unit_chk #(.TOK_CNT(TOK_CNT), .RD_W(RD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .l_sel     (l_sel),
  .l_we      (l_we),
  .l_addr    (l_addr),
  .l_wdat    (l_wdat),
  .l_rdata   (l_rdata),
  .r_sel     (r_sel),
  .r_we      (r_we),
  .r_addr    (r_addr),
  .r_wdat    (r_wdat),
  .r_rdata   (r_rdata),
  .own_l_vec (own_l_vec),
  .own_r_vec (own_r_vec),
  .pend_r_vec(pend_r_vec)
);

// File: tb/sem_token_unit_tb.sv
module sem_token_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TOK_CNT    = 8;
  localparam int AW         = 3;
  localparam int RD_W       = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_sel = 1'b0, l_we = 1'b0, l_wdat = 1'b0;
  logic r_sel = 1'b0, r_we = 1'b0, r_wdat = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [RD_W-1:0] l_rdata, r_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sem_token_unit u_dut (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_we(l_we), .l_addr(l_addr), .l_wdat(l_wdat), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_we(r_we), .r_addr(r_addr), .r_wdat(r_wdat), .r_rdata(r_rdata)
  );

  function automatic logic [RD_W-1:0] fill(input logic b);
    return {RD_W{b}};
  endfunction

  task automatic chk(input string req, input logic [RD_W-1:0] got, input logic [RD_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic idle();
    l_sel = 0; l_we = 0; r_sel = 0; r_we = 0;
  endtask

  // one write cycle on a single port (0 = left, 1 = right)
  task automatic wr(input bit port, input int a, input logic b);
    @(negedge clk);
    if (!port) begin l_sel = 1; l_we = 1; l_addr = AW'(a); l_wdat = b; end
    else       begin r_sel = 1; r_we = 1; r_addr = AW'(a); r_wdat = b; end
    @(negedge clk);
    idle();
  endtask

  task automatic wr_both(input int a, input logic bl, input logic br);
    @(negedge clk);
    l_sel = 1; l_we = 1; l_addr = AW'(a); l_wdat = bl;
    r_sel = 1; r_we = 1; r_addr = AW'(a); r_wdat = br;
    @(negedge clk);
    idle();
  endtask

  // read both views of token a and compare
  task automatic rd(input int a, input logic el, input logic er, input string req);
    @(negedge clk);
    l_sel = 1; l_we = 0; l_addr = AW'(a);
    r_sel = 1; r_we = 0; r_addr = AW'(a);
    @(negedge clk);
    idle();
    chk({req, " left"},  l_rdata, fill(el));
    chk({req, " right"}, r_rdata, fill(er));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R4 reset left", l_rdata, fill(1'b1));
    chk("R4 reset right", r_rdata, fill(1'b1));
    for (int t = 0; t < TOK_CNT; t++) begin
      rd(t, 1, 1, "R4 free after reset");
      wr(0, t, 0);  rd(t, 0, 1, "R2 R3 left takes");
      wr(1, t, 0);  rd(t, 0, 1, "R5 right blocked");
      rd((t + 1) % TOK_CNT, 1, 1, "R1 neighbour free");
      wr(0, t, 1);  rd(t, 1, 0, "R6 handoff to right");
      wr(0, t, 0);  rd(t, 1, 0, "R5 left blocked");
      wr(1, t, 1);  rd(t, 0, 1, "R6 handoff to left");
      wr(0, t, 1);  rd(t, 1, 1, "R2 left release");
      wr(0, t, 1);  rd(t, 1, 1, "R9 stray release free");
      wr(1, t, 0);  wr(0, t, 1); rd(t, 1, 0, "R9 stray release held");
      wr(1, t, 1);  rd(t, 1, 1, "R2 right release");
      wr(0, t, 0);  wr(1, t, 0); wr(1, t, 1); wr(0, t, 1);
      rd(t, 1, 1, "R7 withdrawn request");
      wr_both(t, 0, 0); rd(t, 0, 1, "R8 tie left wins");
      wr(0, t, 1);  rd(t, 1, 0, "R8 right was pending");
      wr(1, t, 1);  rd(t, 1, 1, "R8 cleanup");
      // capture during handoff: left holds, right pending
      wr(0, t, 0);  wr(1, t, 0);
      @(negedge clk);
      l_sel = 1; l_we = 1; l_addr = AW'(t); l_wdat = 1;
      r_sel = 1; r_we = 0; r_addr = AW'(t);
      @(negedge clk);
      idle();
      chk("R10 pre-handoff capture", r_rdata, fill(1'b1));
      @(negedge clk);
      chk("R3 R10 captured value held", r_rdata, fill(1'b1));
      rd(t, 1, 0, "R10 fresh read after handoff");
      wr(1, t, 1);  rd(t, 1, 1, "R1 token free again");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule